// File: doc/BRIEF.md
# RFID Reader Serial Configuration Port

This block sits between a host controller and the digital core of a low-frequency RFID reader front end. The host drives two lines, a serial clock and a serial data line, both sampled into the local system clock domain. A transaction opens with an interface reset, signalled by the data line rising while the serial clock is high. Eight command bits follow, then three diagnostic flags are shifted back out on the single output line. The command word sets the demodulator sampling phase, the amplifier gain and the role of the output line.

Outside a readout, the output line carries one of three things: demodulated receive data, the carrier clock divided by 32, or a forced low level. The forced low level is used when the output line and the data line share one wire into the reader. A mode pin decides whether command bit 3 selects the divided clock or sets the data direction of that shared wire. The block keeps a latch for antenna driver short-circuit shutdown, and every completed write clears it. While the port is idle, the data line keys the carrier on and off.

Top module: `rfid_cfg_port`

## Requirements
- R1: A rising edge on the data line while the serial clock is high starts a new transaction, and internal reset holds while both lines stay high. A data-line rise while the clock is low is ordinary data and never restarts the transfer.
- R2: Data is captured on serial clock rising edges, and the first bit received lands in command bit 0. The command word changes only at the 8th rising edge after an interface reset.
- R3: An interface reset before the 8th edge throws away the bits received so far. The command word keeps its earlier value.
- R4: Status is snapshotted at the 8th edge. The output line then shows driver fault (latched), then low input level after the 9th edge, then PLL unlocked after the 10th edge. Flags that change after the 8th edge do not alter the readout. The readout ends at the 11th edge.
- R5: Clock pulses after the 11th edge, and pulses that no interface reset precedes, leave the command word unchanged.
- R6: samplePhase equals command bit 1 (0 = amplitude, 1 = phase). gainCode is 0 (x240) when bits 7:6 are 00, 1 (x480) when they are 01, and 2 (x960) when bit 7 is 1.
- R7: With sharedLine low, command bit 3 set puts the carrier tick count divided by 32 on the output line. The line starts low and toggles every 16 ticks from reset. With bit 3 clear, the line follows demodIn.
- R8: With sharedLine high, command bit 3 clear (input mode) forces the output line low. Bit 3 set (output mode) passes demodIn, ignores data-line keying and keeps the antenna on. Output mode ends only at an interface reset.
- R9: A shortDet pulse turns antennaOn off and sets the fault flag. Only a completed 8-bit write turns antennaOn back on; a partial transfer does not.
- R10: While no transaction is active and output mode is off, a high data line keys the antenna off and a low data line turns it back on.
- R11: After system reset the command word is 0, gainCode is 0, samplePhase is 0, antennaOn is 1 and the output line follows demodIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| serClk | input | 1 | Host serial clock line |
| serIn | input | 1 | Host serial data / carrier keying line |
| sharedLine | input | 1 | Mode pin: high makes command bit 3 the data-direction bit |
| carrierTick | input | 1 | One-cycle strobe per carrier period |
| demodIn | input | 1 | Demodulated receive data |
| shortDet | input | 1 | Driver short-circuit detection strobe |
| lowLevel | input | 1 | Antenna input level too low flag |
| pllUnlock | input | 1 | PLL out-of-lock flag |
| serOut | output | 1 | Host output line |
| cmdWord | output | 8 | Latched command word |
| samplePhase | output | 1 | Demodulator sampling phase select |
| gainCode | output | 2 | Amplifier gain code |
| antennaOn | output | 1 | Antenna driver enable |

## Verification
The hardest case to reach is the status snapshot. The diagnostic flags have to change in the narrow window between the 8th serial clock edge and the readout clocks. The bench walks the host lines step by step, so it can flip the flags at exactly that point and confirm the old values still come out. It also aborts transfers at chosen bit counts. It sweeps all 256 command words and all 8 flag combinations, with expected values decoded from the bit positions. The divided carrier is checked tick by tick against the count of ticks since reset.

// File: rtl/rfid_cfg_pkg.sv
package rfid_cfg_pkg;
  localparam int CMD_BITS  = 8;
  localparam int STAT_BITS = 3;
  localparam int PHASE_BIT = 1;
  localparam int DIR_BIT   = 3;
  localparam int GAIN_LSB  = 6;

  // Strobes from the port control to the datapath, all one cycle wide.
  typedef struct packed {
    logic ifReset;
    logic shiftEn;
    logic commit;
    logic readAdv;
    logic dataBit;
  } cfg_strobe_t;
endpackage

// File: rtl/rfid_cfg_ctrl.sv
module rfid_cfg_ctrl
  import rfid_cfg_pkg::*;
#(
  parameter int CMD_W       = CMD_BITS,
  parameter int STAT_W      = STAT_BITS,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serIn,
  output cfg_strobe_t strb,
  output logic        inLevel,
  output logic        armed,
  output logic        readPhase
);
  localparam int TOTAL = CMD_W + STAT_W;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] FIRST_RD = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] LAST_ALL = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(TOTAL);

  logic [SYNC_STAGES-1:0] ckPipe, inPipe;
  logic ckS, inS, ckPrev, inPrev;
  logic ckRise, inRise;
  logic rstHold;
  logic [CNT_W-1:0] bitCnt;

  // Both host lines pass through identical synchronizer depths so that
  // their relative order is preserved.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckPipe <= '0;
      inPipe <= '0;
      ckPrev <= 1'b0;
      inPrev <= 1'b0;
    end else begin
      ckPipe <= {ckPipe[SYNC_STAGES-2:0], serClk};
      inPipe <= {inPipe[SYNC_STAGES-2:0], serIn};
      ckPrev <= ckS;
      inPrev <= inS;
    end
  end

  assign ckS     = ckPipe[SYNC_STAGES-1];
  assign inS     = inPipe[SYNC_STAGES-1];
  assign ckRise  = ckS & ~ckPrev;
  assign inRise  = inS & ~inPrev;
  assign inLevel = inS;

  always_comb begin
    strb         = '0;
    strb.dataBit = inS;
    strb.ifReset = inRise & ckS;
    if (!strb.ifReset && !rstHold && armed && ckRise) begin
      if (bitCnt < LAST_CMD)       strb.shiftEn = 1'b1;
      else if (bitCnt == LAST_CMD) strb.commit  = 1'b1;
      else if (bitCnt < LAST_ALL)  strb.readAdv = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstHold <= 1'b0;
      armed   <= 1'b0;
      bitCnt  <= '0;
    end else if (strb.ifReset) begin
      rstHold <= 1'b1;
      armed   <= 1'b1;
      bitCnt  <= '0;
    end else begin
      if (!(ckS && inS)) rstHold <= 1'b0;
      if (rstHold) begin
        bitCnt <= '0;
      end else if (ckRise && armed) begin
        if (bitCnt == LAST_ALL) armed <= 1'b0;
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign readPhase = armed && (bitCnt >= FIRST_RD);

  // R1: an interface reset arms the port from bit zero
  a_r1_reset_arms: assert property (@(posedge clk) disable iff (!rstN)
    strb.ifReset |=> (armed && bitCnt == '0));
  // R5: the bit counter never runs past the end of the frame
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= MAX_CNT);
  // R2: at most one strobe per cycle
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ifReset, strb.shiftEn, strb.commit, strb.readAdv}));
  // R5: leaving the armed state only happens at the frame end
  a_r5_disarm_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(armed) |-> $past(bitCnt == LAST_ALL));
endmodule

// File: rtl/rfid_carrier_div.sv
module rfid_carrier_div #(
  parameter int RATIO = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  output logic divOut
);
  localparam int HALF = RATIO / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divOut <= 1'b0;
    end else if (tick) begin
      if (cnt == LAST) begin
        cnt    <= '0;
        divOut <= ~divOut;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7: the divided clock moves only on a carrier tick
  a_r7_div_steady: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(divOut));
endmodule

// File: rtl/rfid_cfg_datapath.sv
module rfid_cfg_datapath
  import rfid_cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  cfg_strobe_t         strb,
  input  logic                inLevel,
  input  logic                armed,
  input  logic                readPhase,
  input  logic                sharedLine,
  input  logic                demodIn,
  input  logic                shortDet,
  input  logic                lowLevel,
  input  logic                pllUnlock,
  input  logic                divOut,
  output logic                serOut,
  output logic [CMD_BITS-1:0] cmdWord,
  output logic                samplePhase,
  output logic [1:0]          gainCode,
  output logic                antennaOn
);
  logic [CMD_BITS-1:0]  shiftQ, cmdQ, commitWord;
  logic [STAT_BITS-1:0] statQ;
  logic                 faultLatch, dirOutput;

  assign commitWord = {strb.dataBit, shiftQ[CMD_BITS-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ    <= '0;
      cmdQ      <= '0;
      statQ     <= '0;
      dirOutput <= 1'b0;
    end else begin
      if (strb.ifReset) begin
        shiftQ    <= '0;
        dirOutput <= 1'b0;
      end
      if (strb.shiftEn) shiftQ <= commitWord;
      if (strb.commit) begin
        cmdQ      <= commitWord;
        statQ     <= {pllUnlock, lowLevel, faultLatch};
        dirOutput <= sharedLine & commitWord[DIR_BIT];
      end
      if (strb.readAdv) statQ <= statQ >> 1;
    end
  end

  // Short-circuit shutdown: set wins over the clear from a write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            faultLatch <= 1'b0;
    else if (shortDet)    faultLatch <= 1'b1;
    else if (strb.commit) faultLatch <= 1'b0;
  end

  always_comb begin
    if (readPhase)       serOut = statQ[0];
    else if (sharedLine) serOut = dirOutput ? demodIn : 1'b0;
    else                 serOut = cmdQ[DIR_BIT] ? divOut : demodIn;
  end

  assign antennaOn   = !faultLatch && (dirOutput || armed || !inLevel);
  assign cmdWord     = cmdQ;
  assign samplePhase = cmdQ[PHASE_BIT];
  assign gainCode    = cmdQ[GAIN_LSB+1] ? 2'd2 : {1'b0, cmdQ[GAIN_LSB]};

  // R2: the command word holds between commits
  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(cmdQ));
  // R4: snapshot moves only on commit or readout shift
  a_r4_stat_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commit || strb.readAdv) |=> $stable(statQ));
  // R9: the fault latch is released only by a completed write
  a_r9_fault_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLatch) |-> $past(strb.commit));
  // R8: output mode ends only through a new transaction
  a_r8_dir_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dirOutput) |-> $past(strb.ifReset || strb.commit));
endmodule

// File: rtl/rfid_cfg_port.sv
module rfid_cfg_port
  import rfid_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_RATIO   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serClk,
  input  logic                serIn,
  input  logic                sharedLine,
  input  logic                carrierTick,
  input  logic                demodIn,
  input  logic                shortDet,
  input  logic                lowLevel,
  input  logic                pllUnlock,
  output logic                serOut,
  output logic [CMD_BITS-1:0] cmdWord,
  output logic                samplePhase,
  output logic [1:0]          gainCode,
  output logic                antennaOn
);
  cfg_strobe_t strb;
  logic inLevel, armed, readPhase, divOut;

  rfid_cfg_ctrl #(
    .CMD_W(CMD_BITS), .STAT_W(STAT_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serIn(serIn),
    .strb(strb), .inLevel(inLevel), .armed(armed), .readPhase(readPhase)
  );

  rfid_carrier_div #(.RATIO(DIV_RATIO)) u_div (
    .clk(clk), .rstN(rstN), .tick(carrierTick), .divOut(divOut)
  );

  rfid_cfg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inLevel(inLevel), .armed(armed),
    .readPhase(readPhase), .sharedLine(sharedLine), .demodIn(demodIn),
    .shortDet(shortDet), .lowLevel(lowLevel), .pllUnlock(pllUnlock),
    .divOut(divOut), .serOut(serOut), .cmdWord(cmdWord),
    .samplePhase(samplePhase), .gainCode(gainCode), .antennaOn(antennaOn)
  );
endmodule

// File: tb/rfid_cfg_port_test.sv
`timescale 1ns/1ps
module rfid_cfg_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serIn = 1'b0, sharedLine = 1'b0, carrierTick = 1'b0;
  logic demodIn = 1'b0, shortDet = 1'b0, lowLevel = 1'b0, pllUnlock = 1'b0;
  logic serOut, samplePhase, antennaOn;
  logic [7:0] cmdWord;
  logic [1:0] gainCode;
  int total = 0, fails = 0, ticks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rfid_cfg_port uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serIn(serIn),
    .sharedLine(sharedLine), .carrierTick(carrierTick), .demodIn(demodIn),
    .shortDet(shortDet), .lowLevel(lowLevel), .pllUnlock(pllUnlock),
    .serOut(serOut), .cmdWord(cmdWord), .samplePhase(samplePhase),
    .gainCode(gainCode), .antennaOn(antennaOn)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lineStep(input logic c, input logic i);
    @(negedge clk);
    serClk = c;
    serIn  = i;
    repeat (6) @(negedge clk);
  endtask

  task automatic ifaceReset();
    lineStep(0, 0); lineStep(1, 0); lineStep(1, 1); lineStep(0, 1); lineStep(0, 0);
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      lineStep(0, v[k]); lineStep(1, v[k]); lineStep(0, v[k]);
    end
    lineStep(0, 0);
  endtask

  task automatic readStatus(output logic [2:0] s);
    s[0] = serOut;
    for (int k = 1; k < 3; k++) begin
      lineStep(1, 0); lineStep(0, 0);
      s[k] = serOut;
    end
    lineStep(1, 0); lineStep(0, 0);
  endtask

  task automatic writeCmd(input logic [7:0] v);
    logic [2:0] s;
    ifaceReset();
    sendBits(v, 8);
    readStatus(s);
  endtask

  task automatic pulseTick();
    @(negedge clk); carrierTick = 1'b1;
    @(negedge clk); carrierTick = 1'b0;
    ticks++;
  endtask

  initial begin
    logic [2:0] st;
    int expGain;
    demodIn = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 cmdWord", cmdWord, 0);
    check("R11 gainCode", gainCode, 0);
    check("R11 samplePhase", samplePhase, 0);
    check("R11 antennaOn", antennaOn, 1);
    check("R11 serOut follows demod", serOut, 1);

    // R2/R6 sweep over every command word (sharedLine low, bit3 gives div clock)
    for (int v = 0; v < 256; v++) begin
      writeCmd(8'(v));
      expGain = v[7] ? 2 : (v[6] ? 1 : 0);
      check("R2 cmdWord", cmdWord, v);
      check("R6 samplePhase", samplePhase, v & 2 ? 1 : 0);
      check("R6 gainCode", gainCode, expGain);
    end

    // R1: alternating data with data-line rises during clock low
    writeCmd(8'hAA);
    check("R1 no false restart", cmdWord, 8'hAA);

    // R5: pulses without a preceding interface reset
    sendBits(8'h5A, 8);
    check("R5 no reset ignored", cmdWord, 8'hAA);
    // R5: clocks past the 11th edge
    ifaceReset(); sendBits(8'hC3, 8); readStatus(st);
    sendBits(8'h3C, 8);
    check("R5 extra clocks ignored", cmdWord, 8'hC3);

    // R3: reset mid-transfer discards partial bits
    ifaceReset(); sendBits(8'hFF, 5);
    check("R3 partial no update", cmdWord, 8'hC3);
    ifaceReset(); sendBits(8'h3C, 8); readStatus(st);
    check("R3 clean restart", cmdWord, 8'h3C);

    // R4/R9: status readout sweep with snapshot check
    for (int s = 0; s < 8; s++) begin
      lowLevel  = s[1];
      pllUnlock = s[2];
      if (s[0]) begin
        @(negedge clk); shortDet = 1'b1;
        @(negedge clk); shortDet = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 short turns off", antennaOn, 0);
        ifaceReset(); sendBits(8'h00, 4);
        check("R9 partial keeps off", antennaOn, 0);
      end
      ifaceReset(); sendBits(8'h12, 8);
      lowLevel  = ~lowLevel;
      pllUnlock = ~pllUnlock;
      readStatus(st);
      check("R4 status snapshot", st, s);
      check("R9 write re-enables", antennaOn, 1);
    end
    lowLevel = 1'b0; pllUnlock = 1'b0;

    // R10: idle keying
    lineStep(0, 1);
    check("R10 key off", antennaOn, 0);
    lineStep(0, 0);
    check("R10 key on", antennaOn, 1);

    // R7: divided carrier
    writeCmd(8'h08);
    for (int n = 0; n < 70; n++) begin
      pulseTick();
      check("R7 div by 32", serOut, (ticks / 16) & 1);
    end
    writeCmd(8'h00);
    demodIn = 1'b0; @(negedge clk);
    check("R7 demod path low", serOut, 0);
    demodIn = 1'b1; @(negedge clk);
    check("R7 demod path high", serOut, 1);

    // R8: shared line
    sharedLine = 1'b1;
    writeCmd(8'h00);
    check("R8 input mode low", serOut, 0);
    writeCmd(8'h08);
    check("R8 output mode demod1", serOut, 1);
    demodIn = 1'b0; @(negedge clk);
    check("R8 output mode demod0", serOut, 0);
    lineStep(0, 1);
    check("R8 keying ignored", antennaOn, 1);
    lineStep(0, 0);
    sendBits(8'h00, 8);
    demodIn = 1'b1; @(negedge clk);
    check("R8 stays output", serOut, 1);
    writeCmd(8'h00);
    check("R8 reset exits output", serOut, 0);
    sharedLine = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end
endmodule